// File: doc/BRIEF.md
# Graphics aperture address translator

The translator sits between a graphics bus and system memory. A bus address whose top bits fall inside a programmable 256 MiB window (the aperture) is treated as an offset into that window. The page part of the offset selects one 32-bit entry in a page table kept in system memory. The entry supplies the physical page, and the low 12 bits of the address pass through unchanged. Addresses outside the window pass through untouched.

Recent entries are kept in a small fully associative translation cache. On a miss, one read is issued on a simple memory read port. Entries are stored little-endian, so the fetched word is byte-reversed before its page field and valid flag (bit 0) are decoded.

Software programs four word registers: table base with page count, aperture base, control, and a read-only status. The block watches the stream of control writes. Any write carrying the invalidate bit empties the cache. A four-write shutdown pattern stops translation. The four-write invalidate pattern is the only way to resume it.

Top module: `gart_xlate`

## Requirements
- R1: A request whose address bits 31:28 differ from bits 31:28 of the aperture register gets a response with rsp_paddr equal to the request address and rsp_err 0, and no memory read is made.
- R2: For an in-aperture request, the table index is address bits 27:12. On a miss, the entry is read at the word address {table base bits 31:12, 12'b0} + 4*index. The read word is byte-reversed (its bits 7:0 become entry bits 31:24). A valid entry then gives rsp_paddr = {entry bits 31:12, address bits 11:0} with rsp_err 0.
- R3: An entry whose bit 0 is clear gives rsp_err 1 and rsp_paddr 0, and it is not kept in the cache, so asking for it again reads memory again.
- R4: The page count is table base bits 11:0. An index at or above count*1024 gives rsp_err 1 and rsp_paddr 0, and no memory read is made.
- R5: While control bit 8 (enable) is 0, every in-aperture request gives rsp_err 1 and rsp_paddr 0, and no memory read is made.
- R6: req_ready is 1 only while no request is in flight. A request is accepted at the clock edge where req_valid and req_ready are both 1. On a hit or an immediate answer, rsp_valid pulses for one cycle at the second edge after acceptance. On a miss, mem_req pulses for one cycle in the cycle after acceptance, and rsp_valid rises at the edge that ends the cycle in which mem_rvalid is 1 (the memory latency plus 2 cycles after the accept cycle).
- R7: The cache holds 8 translations. A hit makes no memory read. Fills take slots in round-robin order, starting from slot 0 after reset or a flush, so the ninth distinct fill displaces the first.
- R8: A control write with bit 0 set empties the cache from the next cycle on. A fill whose mem_rvalid falls in the same cycle as that write is still answered, but it is not kept.
- R9: Four consecutive control writes with bits {16,8,0} equal to 011, 000, 100, 000 put the block in the stopped state. While stopped, in-aperture requests get rsp_err 1 and make no memory read, even with enable set. Only four consecutive control writes coded 011, 010, 110, 010 leave the stopped state. Writes to other registers do not break either pattern.
- R10: Registers are selected by a 2-bit code: 0 table base, 1 aperture (reads back bits 31:28 with zeros below), 2 control (reads back the full written word), 3 status (bit 0 idle, bit 1 stopped, the other bits 0; writes are ignored). reg_rdata shows the register chosen by reg_rsel in the same cycle. After reset, every register reads 0 except status, which reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Register selected for the write |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 2 | Register selected for the read |
| reg_rdata | output | 32 | Read data (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_err | output | 1 | Translation refused |
| mem_req | output | 1 | Page-table read request (one cycle) |
| mem_addr | output | 32 | Byte address of the entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry word as stored in memory |

## Verification
Two events can collide: the return of a page-table word and a control write carrying the invalidate bit. The bench watches for mem_rvalid at the falling edge and places the invalidate write in that same cycle. It then checks that the response still carries the correct translation, and that a repeat request for the same page issues a fresh memory read, which shows that the flush won over the fill. Around this, a sweep of indices checks the address arithmetic, the validity decode and the latency. The round-robin eviction order and the two control-write patterns are checked through the read count and the status register.

// File: rtl/gart_pkg.sv
package gart_pkg;

   localparam logic [1:0] SEL_TBASE = 2'd0;
   localparam logic [1:0] SEL_APER  = 2'd1;
   localparam logic [1:0] SEL_CTRL  = 2'd2;
   localparam logic [1:0] SEL_STAT  = 2'd3;

   localparam int unsigned CB_INV = 0;
   localparam int unsigned CB_EN  = 8;
   localparam int unsigned CB_RST = 16;

   // control write codes {rst, en, inv}, first step in the top bits
   localparam logic [11:0] PAT_RESUME = {3'b011, 3'b010, 3'b110, 3'b010};
   localparam logic [11:0] PAT_HALT   = {3'b011, 3'b000, 3'b100, 3'b000};

   typedef enum logic [1:0] {XS_IDLE, XS_LOOK, XS_WAIT} xl_state_t;

   function automatic logic [31:0] byte_rev32(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   function automatic logic [2:0] pat_step(input logic [11:0] pat, input logic [1:0] n);
      case (n)
         2'd0:    return pat[11:9];
         2'd1:    return pat[8:6];
         2'd2:    return pat[5:3];
         default: return pat[2:0];
      endcase
   endfunction

   // returns {done, next step}
   function automatic logic [2:0] pat_adv(input logic [11:0] pat, input logic [1:0] st,
                                          input logic [2:0] code);
      if (code == pat_step(pat, st)) begin
         if (st == 2'd3) return 3'b100;
         return {1'b0, st + 2'd1};
      end
      if (code == pat_step(pat, 2'd0)) return 3'b001;
      return 3'b000;
   endfunction

endpackage

// File: rtl/gart_cfg_regs.sv
module gart_cfg_regs
   import gart_pkg::*;
#(
   parameter int unsigned APER_BITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [31:0]          wr_data,
   input  logic [1:0]           rd_sel,
   output logic [31:0]          rd_data,
   input  logic                 idle_i,
   output logic [31:0]          tbase_o,
   output logic [APER_BITS-1:0] aper_o,
   output logic                 enable_o,
   output logic                 stopped_o,
   output logic                 flush_o
);

   localparam int unsigned LOW_W = 32 - APER_BITS;

   if (APER_BITS < 1 || APER_BITS > 16) begin : g_bad_aper
      $error("gart_cfg_regs: APER_BITS out of range");
   end

   logic [31:0]          tbase_q, ctl_q;
   logic [APER_BITS-1:0] aper_q;
   logic                 stopped_q;
   logic [1:0]           res_st_q, halt_st_q;
   logic [2:0]           code, res_nx, halt_nx;
   logic                 ctl_wr;

   assign ctl_wr  = wr_en && (wr_sel == SEL_CTRL);
   assign code    = {wr_data[CB_RST], wr_data[CB_EN], wr_data[CB_INV]};
   assign res_nx  = pat_adv(PAT_RESUME, res_st_q, code);
   assign halt_nx = pat_adv(PAT_HALT, halt_st_q, code);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbase_q   <= '0;
         ctl_q     <= '0;
         aper_q    <= '0;
         stopped_q <= 1'b0;
         res_st_q  <= '0;
         halt_st_q <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_TBASE: tbase_q <= wr_data;
            SEL_APER:  aper_q  <= wr_data[31 -: APER_BITS];
            SEL_CTRL: begin
               ctl_q     <= wr_data;
               res_st_q  <= res_nx[1:0];
               halt_st_q <= halt_nx[1:0];
               if (halt_nx[2])     stopped_q <= 1'b1;
               else if (res_nx[2]) stopped_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_sel)
         SEL_TBASE: rd_data = tbase_q;
         SEL_APER:  rd_data = {aper_q, LOW_W'(0)};
         SEL_CTRL:  rd_data = ctl_q;
         default:   rd_data = {30'd0, stopped_q, idle_i};
      endcase
   end

   assign tbase_o   = tbase_q;
   assign aper_o    = aper_q;
   assign enable_o  = ctl_q[CB_EN];
   assign stopped_o = stopped_q;
   assign flush_o   = ctl_wr && wr_data[CB_INV];

   // stopping only follows the last (all-zero) write of the halt pattern
   assert_halt_on_zero_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stopped_q) |-> $past(ctl_wr && (code == 3'b000)));

   // leaving the stopped state only follows an enable-only write
   assert_resume_on_en_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stopped_q) |-> $past(ctl_wr && (code == 3'b010)));

endmodule

// File: rtl/gart_tlb.sv
module gart_tlb #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned TAG_W   = 16,
   parameter int unsigned DATA_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              flush
);

   localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_depth
      $error("gart_tlb: ENTRIES must be 2..64");
   end

   logic [ENTRIES-1:0] valid_q, hit_vec;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];
   logic [PTR_W-1:0]   ptr_q;
   logic               do_fill;

   assign do_fill = fill_en && !flush;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_way
      assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_tag);

      always_ff @(posedge clk) begin
         if (do_fill && (ptr_q == PTR_W'(g))) begin
            tag_q[g]  <= fill_tag;
            data_q[g] <= fill_data;
         end
      end
   end

   always_comb begin
      lk_data = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) lk_data = lk_data | data_q[i];
      end
   end
   assign lk_hit = |hit_vec;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         valid_q <= '0;
         ptr_q   <= '0;
      end else if (do_fill) begin
         valid_q[ptr_q] <= 1'b1;
         ptr_q          <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

   assert_single_hit_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   assert_flush_empties_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));

   assert_fill_grows_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (do_fill && !valid_q[ptr_q]) |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));

endmodule

// File: rtl/gart_xlate.sv
module gart_xlate
   import gart_pkg::*;
#(
   parameter int unsigned TLB_ENTRIES  = 8,
   parameter int unsigned PAGE_SHIFT   = 12,
   parameter int unsigned APER_BITS    = 4,
   parameter int unsigned CNT_W        = 12,
   parameter bit          SWAP_ENTRIES = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [1:0]  reg_wsel,
   input  logic [31:0] reg_wdata,
   input  logic [1:0]  reg_rsel,
   output logic [31:0] reg_rdata,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [31:0] req_addr,
   output logic        rsp_valid,
   output logic [31:0] rsp_paddr,
   output logic        rsp_err,
   output logic        mem_req,
   output logic [31:0] mem_addr,
   input  logic        mem_rvalid,
   input  logic [31:0] mem_rdata
);

   localparam int unsigned AW        = 32;
   localparam int unsigned IDX_W     = AW - APER_BITS - PAGE_SHIFT;
   localparam int unsigned PPN_W     = AW - PAGE_SHIFT;
   localparam int unsigned EPP_SHIFT = PAGE_SHIFT - 2;
   localparam int unsigned LIM_W     = CNT_W + EPP_SHIFT;
   localparam int unsigned CMP_W     = ((LIM_W > IDX_W) ? LIM_W : IDX_W) + 1;

   if (CNT_W > PAGE_SHIFT || PAGE_SHIFT < 3) begin : g_bad_page
      $error("gart_xlate: page count must fit below the page-aligned base");
   end
   if (APER_BITS + PAGE_SHIFT >= AW) begin : g_bad_split
      $error("gart_xlate: no index bits left");
   end

   xl_state_t             state_q;
   logic [AW-1:0]         cur_q;
   logic                  rv_q, rerr_q;
   logic [AW-1:0]         rpa_q;

   logic [AW-1:0]         tbase;
   logic [APER_BITS-1:0]  aper;
   logic                  enable, stopped, flush;

   logic [IDX_W-1:0]      idx;
   logic [PAGE_SHIFT-1:0] pg_off;
   logic                  in_ap, oob, trans_on;
   logic [CMP_W-1:0]      idx_x, lim_x;
   logic                  hit;
   logic [PPN_W-1:0]      hit_ppn;
   logic [AW-1:0]         ent;
   logic                  ent_unused_bits;
   logic                  look_go_mem;
   logic [AW-1:0]         look_pa;
   logic                  look_err;

   gart_cfg_regs #(.APER_BITS(APER_BITS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .wr_sel    (reg_wsel),
      .wr_data   (reg_wdata),
      .rd_sel    (reg_rsel),
      .rd_data   (reg_rdata),
      .idle_i    (state_q == XS_IDLE),
      .tbase_o   (tbase),
      .aper_o    (aper),
      .enable_o  (enable),
      .stopped_o (stopped),
      .flush_o   (flush)
   );

   // address split and window checks
   assign idx      = cur_q[AW-APER_BITS-1 : PAGE_SHIFT];
   assign pg_off   = cur_q[PAGE_SHIFT-1:0];
   assign in_ap    = (cur_q[AW-1 -: APER_BITS] == aper);
   assign idx_x    = CMP_W'(idx);
   assign lim_x    = CMP_W'(tbase[CNT_W-1:0]) << EPP_SHIFT;
   assign oob      = (idx_x >= lim_x);
   assign trans_on = enable && !stopped;

   assign mem_addr = {tbase[AW-1:PAGE_SHIFT], PAGE_SHIFT'(0)} + AW'({idx, 2'b00});

   if (SWAP_ENTRIES) begin : g_le_entry
      assign ent = byte_rev32(mem_rdata);
   end else begin : g_be_entry
      assign ent = mem_rdata;
   end
   assign ent_unused_bits = ^ent[PAGE_SHIFT-1:1];

   gart_tlb #(
      .ENTRIES (TLB_ENTRIES),
      .TAG_W   (IDX_W),
      .DATA_W  (PPN_W)
   ) u_tlb (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_tag    (idx),
      .lk_hit    (hit),
      .lk_data   (hit_ppn),
      .fill_en   ((state_q == XS_WAIT) && mem_rvalid && ent[0]),
      .fill_tag  (idx),
      .fill_data (ent[AW-1:PAGE_SHIFT]),
      .flush     (flush)
   );

   always_comb begin
      look_go_mem = 1'b0;
      look_pa     = '0;
      look_err    = 1'b0;
      if (!in_ap) begin
         look_pa = cur_q;
      end else if (!trans_on || oob) begin
         look_err = 1'b1;
      end else if (hit) begin
         look_pa = {hit_ppn, pg_off};
      end else begin
         look_go_mem = 1'b1;
      end
   end

   assign mem_req   = (state_q == XS_LOOK) && look_go_mem;
   assign req_ready = (state_q == XS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         cur_q   <= '0;
         rv_q    <= 1'b0;
         rpa_q   <= '0;
         rerr_q  <= 1'b0;
      end else begin
         rv_q <= 1'b0;
         case (state_q)
            XS_IDLE: if (req_valid) begin
               cur_q   <= req_addr;
               state_q <= XS_LOOK;
            end
            XS_LOOK: if (look_go_mem) begin
               state_q <= XS_WAIT;
            end else begin
               rv_q    <= 1'b1;
               rpa_q   <= look_pa;
               rerr_q  <= look_err;
               state_q <= XS_IDLE;
            end
            XS_WAIT: if (mem_rvalid) begin
               rv_q    <= 1'b1;
               rpa_q   <= ent[0] ? {ent[AW-1:PAGE_SHIFT], pg_off} : '0;
               rerr_q  <= !ent[0];
               state_q <= XS_IDLE;
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   assign rsp_valid = rv_q;
   assign rsp_paddr = rpa_q;
   assign rsp_err   = rerr_q;

   assert_mem_pulse_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   assert_busy_after_accept_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_answer_after_data_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rvalid && !req_ready && !mem_req) |=> rsp_valid);

   assert_err_zero_addr_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_paddr == '0));

   assert_no_read_when_off_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!enable || stopped) |-> !mem_req);

endmodule

// File: tb/tb_gart_xlate.sv
module tb_gart_xlate;
   import gart_pkg::*;

   localparam int MEM_LAT = 3;
   localparam logic [31:0] TB_BASE = 32'h0012_3000;
   localparam logic [3:0]  APN     = 4'h3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_wsel = '0;
   logic [31:0] reg_wdata = '0;
   logic [1:0]  reg_rsel = SEL_STAT;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        rsp_valid, rsp_err, mem_req, mem_rvalid;
   logic [31:0] rsp_paddr, mem_addr, mem_rdata;

   int n_checks = 0;
   int n_errs   = 0;
   int reads    = 0;

   always #5 clk = ~clk;

   gart_xlate dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
      .reg_rsel(reg_rsel), .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   // ---- table contents computed from the index ----
   function automatic logic [19:0] t_ppn(input int i);
      return 20'((i * 37 + 32'h12345) & 32'hFFFFF);
   endfunction
   function automatic bit t_ok(input int i);
      return (i % 5) != 2;
   endfunction
   function automatic logic [31:0] t_word(input logic [31:0] a);
      int i;
      logic [31:0] e;
      i = int'((a - TB_BASE) >> 2);
      e = {t_ppn(i), 11'h5A5, t_ok(i)};
      return {e[7:0], e[15:8], e[23:16], e[31:24]};
   endfunction

   // ---- memory model with fixed latency ----
   logic [MEM_LAT-1:0] pv;
   logic [31:0]        pa [MEM_LAT];
   always @(posedge clk) begin
      if (!rst_n) pv <= '0;
      else        pv <= {pv[MEM_LAT-2:0], mem_req};
      pa[0] <= mem_addr;
      for (int i = 1; i < MEM_LAT; i++) pa[i] <= pa[i-1];
      if (rst_n && mem_req) reads <= reads + 1;
   end
   assign mem_rvalid = pv[MEM_LAT-1];
   assign mem_rdata  = t_word(pa[MEM_LAT-1]);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_wsel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_rsel = sel;
      #1;
      chk(reg_rdata == exp, req, reg_rdata, exp);
      reg_rsel = SEL_STAT;
   endtask

   function automatic logic [31:0] ap_addr(input int i, input int off);
      return {APN, 16'(i), 12'(off)};
   endfunction

   // issue one request and judge the response, read count and latency
   task automatic xreq(input logic [31:0] a, input bit e_err, input logic [31:0] e_pa,
                       input int e_reads, input int e_lat, input bit coll, input string req);
      int r0;
      int k;
      r0 = reads;
      k  = 0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      k = 1;
      chk(reg_rdata[0] == 1'b0, "R10 status idle low in flight", reg_rdata, 32'h0);
      while (!rsp_valid) begin
         if (coll && mem_rvalid) begin
            reg_wr = 1'b1; reg_wsel = SEL_CTRL; reg_wdata = 32'h0000_0101;
         end
         @(negedge clk);
         reg_wr = 1'b0;
         k++;
      end
      chk(rsp_err == e_err, {req, " err"}, 32'(rsp_err), 32'(e_err));
      chk(rsp_paddr == e_pa, {req, " paddr"}, rsp_paddr, e_pa);
      chk(reads - r0 == e_reads, {req, " memory reads"}, 32'(reads - r0), 32'(e_reads));
      if (e_lat > 0) chk(k == e_lat, {req, " latency R6"}, 32'(k), 32'(e_lat));
   endtask

   localparam int LHIT  = 2;
   localparam int LMISS = MEM_LAT + 2;

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin : main
      int pg[9];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(req_ready && !rsp_valid && !mem_req, "R10 reset outputs", {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
      rd(SEL_STAT, 32'h1, "R10 status after reset");
      rd(SEL_CTRL, 32'h0, "R10 control after reset");
      rd(SEL_TBASE, 32'h0, "R10 table base after reset");

      wr(SEL_TBASE, TB_BASE | 32'h1);
      wr(SEL_APER, 32'h3ABC_DEF0);
      wr(SEL_STAT, 32'hFFFF_FFFF);
      rd(SEL_APER, 32'h3000_0000, "R10 aperture readback");
      rd(SEL_TBASE, TB_BASE | 32'h1, "R10 table base readback");
      rd(SEL_STAT, 32'h1, "R10 status write ignored");

      // R5 disabled
      xreq(ap_addr(4, 12'h123), 1'b1, 32'h0, 0, LHIT, 1'b0, "R5 disabled");
      wr(SEL_CTRL, 32'h0000_0100);
      rd(SEL_CTRL, 32'h0000_0100, "R10 control readback");

      // R1 outside the window
      xreq(32'h5123_4567, 1'b0, 32'h5123_4567, 0, LHIT, 1'b0, "R1 outside window");
      xreq(32'h2FFF_FFFF, 1'b0, 32'h2FFF_FFFF, 0, LHIT, 1'b0, "R1 below window");

      // R2/R3 sweep of fresh indices
      for (int i = 0; i < 40; i++) begin
         int off;
         off = (i * 97) & 12'hFFF;
         if (t_ok(i))
            xreq(ap_addr(i, off), 1'b0, {t_ppn(i), 12'(off)}, 1, LMISS, 1'b0, "R2 sweep translate");
         else
            xreq(ap_addr(i, off), 1'b1, 32'h0, 1, LMISS, 1'b0, "R3 sweep invalid entry");
      end

      // R4 bounds
      xreq(ap_addr(1024, 5), 1'b1, 32'h0, 0, LHIT, 1'b0, "R4 index at limit");
      xreq(ap_addr(1023, 5), 1'b0, {t_ppn(1023), 12'h005}, 1, LMISS, 1'b0, "R4 last index in range");
      wr(SEL_TBASE, TB_BASE);
      xreq(ap_addr(0, 0), 1'b1, 32'h0, 0, LHIT, 1'b0, "R4 zero page count");
      wr(SEL_TBASE, TB_BASE | 32'h2);
      xreq(ap_addr(1500, 7), 1'b0, {t_ppn(1500), 12'h007}, 1, LMISS, 1'b0, "R4 two pages");

      // R7 cache fill, hits, round-robin eviction
      wr(SEL_CTRL, 32'h0000_0101);
      wr(SEL_CTRL, 32'h0000_0100);
      pg = '{200, 201, 203, 204, 205, 206, 208, 209, 210};
      for (int j = 0; j < 8; j++)
         xreq(ap_addr(pg[j], j), 1'b0, {t_ppn(pg[j]), 12'(j)}, 1, LMISS, 1'b0, "R7 fill");
      for (int j = 0; j < 8; j++)
         xreq(ap_addr(pg[j], 12'hABC), 1'b0, {t_ppn(pg[j]), 12'hABC}, 0, LHIT, 1'b0, "R7 hit");
      xreq(ap_addr(210, 1), 1'b0, {t_ppn(210), 12'h001}, 1, LMISS, 1'b0, "R7 ninth fill");
      xreq(ap_addr(201, 2), 1'b0, {t_ppn(201), 12'h002}, 0, LHIT, 1'b0, "R7 second slot kept");
      xreq(ap_addr(200, 3), 1'b0, {t_ppn(200), 12'h003}, 1, LMISS, 1'b0, "R7 first slot evicted");

      // R3 invalid entries are not kept
      xreq(ap_addr(202, 0), 1'b1, 32'h0, 1, LMISS, 1'b0, "R3 invalid first");
      xreq(ap_addr(202, 0), 1'b1, 32'h0, 1, LMISS, 1'b0, "R3 invalid again");

      // R8 flush
      wr(SEL_CTRL, 32'h0000_0101);
      xreq(ap_addr(203, 4), 1'b0, {t_ppn(203), 12'h004}, 1, LMISS, 1'b0, "R8 miss after flush");
      xreq(ap_addr(203, 4), 1'b0, {t_ppn(203), 12'h004}, 0, LHIT, 1'b0, "R8 refill hits");

      // R8 flush colliding with a fill
      xreq(ap_addr(300, 9), 1'b0, {t_ppn(300), 12'h009}, 1, LMISS, 1'b1, "R8 collision answer");
      xreq(ap_addr(300, 9), 1'b0, {t_ppn(300), 12'h009}, 1, LMISS, 1'b0, "R8 collided fill dropped");
      xreq(ap_addr(203, 4), 1'b0, {t_ppn(203), 12'h004}, 1, LMISS, 1'b0, "R8 collision flushed all");
      wr(SEL_CTRL, 32'h0000_0100);

      // R9 halt and resume patterns
      rd(SEL_STAT, 32'h1, "R9 idle before halt");
      wr(SEL_CTRL, 32'h0000_0101);
      wr(SEL_CTRL, 32'h0000_0000);
      wr(SEL_APER, 32'h3000_0000);
      wr(SEL_CTRL, 32'h0001_0000);
      wr(SEL_CTRL, 32'h0000_0000);
      rd(SEL_STAT, 32'h3, "R9 stopped after halt pattern");
      wr(SEL_CTRL, 32'h0000_0100);
      xreq(ap_addr(203, 4), 1'b1, 32'h0, 0, LHIT, 1'b0, "R9 stopped with enable");
      xreq(32'h7000_0010, 1'b0, 32'h7000_0010, 0, LHIT, 1'b0, "R9 R1 outside still passes");
      wr(SEL_CTRL, 32'h0000_0101);
      wr(SEL_CTRL, 32'h0000_0100);
      wr(SEL_CTRL, 32'h0001_0100);
      rd(SEL_STAT, 32'h3, "R9 still stopped before last write");
      wr(SEL_CTRL, 32'h0000_0100);
      rd(SEL_STAT, 32'h1, "R9 resumed");
      xreq(ap_addr(204, 8), 1'b0, {t_ppn(204), 12'h008}, 1, LMISS, 1'b0, "R9 translating again");

      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule